// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that runs a fixed subset of a 32-bit load/store instruction set. Every instruction is fetched, decoded, executed and retired in one clock cycle. The core holds its own instruction store and data store as internal word arrays. It also contains the program counter, a 32-entry register bank with two read ports and one write port, an ALU that reports zero and signed overflow, an opcode decoder with a function-field decoder, and next-address selection for straight-line code, conditional branches and absolute jumps.

Both stores are filled through a load port that uses a valid/ready handshake. The port raises ready only while the core is held in reset, so a word moves on an edge where valid and ready are both high. When ready is low, valid is ignored and the producer must hold its word. The load port is the only data interface of the core. Its effects are observed on plain status pins that show the current PC, the register write-back about to take place, the data-store write about to take place, and the overflow flag.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. During reset, `rf_we_o` and `dm_we_o` stay low.
- R2: The PC increases by 4 on every clock after reset unless a taken `beq` or a `j` redirects it. The instruction word is read at PC bits [AW+1:2]. Field positions are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump index [25:0].
- R3: For opcode 0x00 with funct add 0x20, addu 0x21, sub 0x22, subu 0x23, and 0x24, or 0x25, xor 0x26 or nor 0x27, the result of rs op rt is written to rd. Any other funct value writes nothing.
- R4: slt (funct 0x2A) writes 1 to rd when rs < rt as signed values, and 0 otherwise. sltu (funct 0x2B) does the same with an unsigned compare.
- R5: lw (opcode 0x23) writes the data word at rs + sign-extended immediate into rt. The data word is indexed by address bits [AW+1:2].
- R6: sw (opcode 0x2B) writes rt to the data word at rs + sign-extended immediate and never writes the register bank.
- R7: ori (opcode 0x0D) writes rs OR the zero-extended immediate into rt.
- R8: beq (opcode 0x04) sets PC to PC+4+(sign-extended immediate shifted left 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R9: j (opcode 0x02) sets PC to {PC+4 bits [31:28], index, 2'b00}. It writes no register.
- R10: Register 0 always reads as zero. A write to register 0 has no effect.
- R11: `ovf_o` is high only for add and sub whose signed result overflows. The result is still written.
- R12: `ld_ready` equals `rst`. A load-port word is stored only on an edge where `ld_valid` and `ld_ready` are both high. `ld_dmem` = 1 selects the data store and 0 selects the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted (reset only) |
| ld_dmem | input | 1 | 1: data store, 0: instruction store |
| ld_index | input | AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Current PC |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-store write this cycle |
| dm_addr_o | output | 32 | Data byte address |
| dm_wdata_o | output | 32 | Data-store write value |
| ovf_o | output | 1 | Signed overflow of add/sub |

## Verification
The bench builds the core with MEM_WORDS = 64, so AW is 6 and both stores are indexed by address bits [7:2]. At this size the whole program fits in the low words. Forward and backward branches and an absolute jump all land inside the store. A store followed by loads through positive and negative offsets reaches the same word. A reference model with matching 64-word arrays compares PC, write-back and store activity against the core on every clock.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XW = 32;
  localparam int RAW = 5;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    AOP_ADD, AOP_ADDU, AOP_SUB, AOP_SUBU, AOP_AND,
    AOP_OR, AOP_XOR, AOP_NOR, AOP_SLT, AOP_SLTU
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    src_imm;
    logic    zext;
    logic    mem_to_rf;
    logic    dm_we;
    logic    branch;
    logic    jump;
    alu_op_e alu;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl.rf_we     = 1'b0;
    ctl.dst_rd    = 1'b0;
    ctl.src_imm   = 1'b0;
    ctl.zext      = 1'b0;
    ctl.mem_to_rf = 1'b0;
    ctl.dm_we     = 1'b0;
    ctl.branch    = 1'b0;
    ctl.jump      = 1'b0;
    ctl.alu       = AOP_ADDU;
    unique case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu = AOP_ADD;
          FN_ADDU: ctl.alu = AOP_ADDU;
          FN_SUB:  ctl.alu = AOP_SUB;
          FN_SUBU: ctl.alu = AOP_SUBU;
          FN_AND:  ctl.alu = AOP_AND;
          FN_OR:   ctl.alu = AOP_OR;
          FN_XOR:  ctl.alu = AOP_XOR;
          FN_NOR:  ctl.alu = AOP_NOR;
          FN_SLT:  ctl.alu = AOP_SLT;
          FN_SLTU: ctl.alu = AOP_SLTU;
          default: ctl.rf_we = 1'b0;
        endcase
      end
      OPC_LDW: begin
        ctl.rf_we     = 1'b1;
        ctl.src_imm   = 1'b1;
        ctl.mem_to_rf = 1'b1;
      end
      OPC_STW: begin
        ctl.dm_we   = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OPC_ORI: begin
        ctl.rf_we   = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.zext    = 1'b1;
        ctl.alu     = AOP_OR;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu    = AOP_SUBU;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  logic [W-1:0] sum, dif;
  assign sum = a + b;
  assign dif = a - b;

  always_comb begin
    ovf = 1'b0;
    unique case (op)
      AOP_ADD: begin
        y   = sum;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      AOP_ADDU: y = sum;
      AOP_SUB: begin
        y   = dif;
        ovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
      end
      AOP_SUBU: y = dif;
      AOP_AND:  y = a & b;
      AOP_OR:   y = a | b;
      AOP_XOR:  y = a ^ b;
      AOP_NOR:  y = ~(a | b);
      AOP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      AOP_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      default:  y = sum;
    endcase
  end

  assign zero = (dif == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREG  = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [W-1:0]            wd,
  input  logic [NRD-1:0][AW-1:0]  ra,
  output logic [NRD-1:0][W-1:0]   rd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_valid,
  output logic                         ld_ready,
  input  logic                         ld_dmem,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_index,
  input  logic [31:0]                  ld_data,
  output logic [31:0]                  pc_o,
  output logic                         rf_we_o,
  output logic [4:0]                   rf_waddr_o,
  output logic [31:0]                  rf_wdata_o,
  output logic                         dm_we_o,
  output logic [31:0]                  dm_addr_o,
  output logic [31:0]                  dm_wdata_o,
  output logic                         ovf_o
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [XW-1:0] imem [MEM_WORDS];
  logic [XW-1:0] dmem [MEM_WORDS];

  logic [XW-1:0] pc_q, pc_plus4, br_target, jmp_target, instr;
  logic [XW-1:0] imm_ext, alu_b, alu_y, ld_word;
  logic [1:0][RAW-1:0] rsel;
  logic [1:0][XW-1:0]  rval;
  logic alu_zero, alu_ovf, ld_fire;
  ctrl_t ctl;

  // load port: accepts only while the core is held in reset
  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_dmem) imem[ld_index] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && ld_dmem) dmem[ld_index] <= ld_data;
    else if (dm_we_o)       dmem[alu_y[AW+1:2]] <= rval[1];
  end

  assign instr = imem[pc_q[AW+1:2]];

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign rsel[0] = instr[25:21];
  assign rsel[1] = instr[20:16];

  sc_regfile #(.W(XW), .NREG(32), .NRD(2)) u_rf (
    .clk (clk),
    .we  (rf_we_o),
    .wa  (rf_waddr_o),
    .wd  (rf_wdata_o),
    .ra  (rsel),
    .rd  (rval)
  );

  assign imm_ext = ctl.zext ? {16'h0000, instr[15:0]}
                            : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctl.src_imm ? imm_ext : rval[1];

  sc_alu #(.W(XW)) u_alu (
    .a    (rval[0]),
    .b    (alu_b),
    .op   (ctl.alu),
    .y    (alu_y),
    .zero (alu_zero),
    .ovf  (alu_ovf)
  );

  assign ld_word    = dmem[alu_y[AW+1:2]];
  assign rf_we_o    = ctl.rf_we && !rst;
  assign rf_waddr_o = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_wdata_o = ctl.mem_to_rf ? ld_word : alu_y;
  assign dm_we_o    = ctl.dm_we && !rst;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rval[1];
  assign ovf_o      = alu_ovf;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_ff @(posedge clk) begin
    if (rst)                          pc_q <= '0;
    else if (ctl.jump)                pc_q <= jmp_target;
    else if (ctl.branch && alu_zero)  pc_q <= br_target;
    else                              pc_q <= pc_plus4;
  end
  assign pc_o = pc_q;

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc_q == '0);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.branch && !ctl.jump) |=> pc_q == $past(pc_q) + 32'd4);

  assert_no_regwr_on_store_R6: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o);

  assert_beq_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && (rval[0] == rval[1])) |=>
      pc_q == $past(pc_q + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00}));

  assert_ovf_addsub_R11: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (ctl.rf_we && (ctl.alu == AOP_ADD || ctl.alu == AOP_SUB)));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int MW = 64;
  localparam int AW = $clog2(MW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_dmem = 1'b0;
  logic [AW-1:0] ld_index = '0;
  logic [31:0] ld_data = '0;
  logic ld_ready, rf_we_o, dm_we_o, ovf_o;
  logic [4:0] rf_waddr_o;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;

  always #4 clk = ~clk;

  sc_core #(.MEM_WORDS(MW)) i_sc_core (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_dmem(ld_dmem), .ld_index(ld_index), .ld_data(ld_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o), .ovf_o(ovf_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mi [MW];
  logic [31:0] md [MW];
  logic [31:0] mr [32];
  logic [31:0] mpc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rt_i(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] im_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] jm_i(input int idx);
    return {6'h02, 26'(idx)};
  endfunction

  // one reference step: compare the current cycle, then commit model state
  task automatic step();
    logic [31:0] ins, a, b, res, sx, addr, npc;
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, wa;
    bit we, dw, ov;
    string tag;
    ins = mi[mpc[AW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = (rs == 0) ? 32'h0 : mr[rs];
    b = (rt == 0) ? 32'h0 : mr[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 4; we = 0; dw = 0; ov = 0; res = 0; wa = 0; addr = 0;
    tag = "R2";
    case (op)
      6'h00: begin
        we = 1; wa = rd; tag = "R3";
        case (fn)
          6'h20: begin res = a + b; ov = (a[31] == b[31]) && (res[31] != a[31]); tag = "R11"; end
          6'h21: res = a + b;
          6'h22: begin res = a - b; ov = (a[31] != b[31]) && (res[31] != a[31]); tag = "R11"; end
          6'h23: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h26: res = a ^ b;
          6'h27: res = ~(a | b);
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
          6'h2B: begin res = (a < b) ? 1 : 0; tag = "R4"; end
          default: we = 0;
        endcase
      end
      6'h23: begin addr = a + sx; res = md[addr[AW+1:2]]; we = 1; wa = rt; tag = "R5"; end
      6'h2B: begin addr = a + sx; dw = 1; tag = "R6"; end
      6'h0D: begin res = a | {16'h0, ins[15:0]}; we = 1; wa = rt; tag = "R7"; end
      6'h04: begin if (a == b) npc = mpc + 4 + {sx[29:0], 2'b00}; tag = "R8"; end
      6'h02: begin npc = {mpc[31:28] + 4'(0), ins[25:0], 2'b00}; npc[31:28] = (mpc + 4) >> 28; tag = "R9"; end
      default: ;
    endcase
    if (we && wa == 0) tag = "R10";
    chk(pc_o == mpc, tag, "pc", pc_o, mpc);
    chk(rf_we_o == we, tag, "rf_we", 32'(rf_we_o), 32'(we));
    if (we) begin
      chk(rf_waddr_o == wa, tag, "waddr", 32'(rf_waddr_o), 32'(wa));
      chk(rf_wdata_o == res, tag, "wdata", rf_wdata_o, res);
    end
    chk(dm_we_o == dw, tag, "dm_we", 32'(dm_we_o), 32'(dw));
    if (dw) begin
      chk(dm_addr_o == addr, tag, "daddr", dm_addr_o, addr);
      chk(dm_wdata_o == b, tag, "dwdata", dm_wdata_o, b);
    end
    chk(ovf_o == ov, "R11", "ovf", 32'(ovf_o), 32'(ov));
    if (we && wa != 0) mr[wa] = res;
    if (dw) md[addr[AW+1:2]] = b;
    mpc = npc;
  endtask

  task automatic load(input bit to_d, input int idx, input logic [31:0] w);
    ld_valid = 1; ld_dmem = to_d; ld_index = AW'(idx); ld_data = w;
    if (to_d) md[idx] = w; else mi[idx] = w;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] prog [32];
    prog[0]  = im_i(6'h0D, 0, 1, 16'h7fff);
    prog[1]  = im_i(6'h0D, 0, 2, 16'hffff);
    prog[2]  = im_i(6'h23, 0, 3, 16'd4);
    prog[3]  = im_i(6'h23, 0, 4, 16'd8);
    prog[4]  = rt_i(3, 4, 5, 6'h20);
    prog[5]  = rt_i(3, 4, 6, 6'h21);
    prog[6]  = rt_i(1, 2, 7, 6'h22);
    prog[7]  = rt_i(2, 1, 8, 6'h23);
    prog[8]  = rt_i(1, 2, 9, 6'h24);
    prog[9]  = rt_i(1, 2, 10, 6'h25);
    prog[10] = rt_i(1, 2, 11, 6'h26);
    prog[11] = rt_i(1, 2, 12, 6'h27);
    prog[12] = rt_i(7, 1, 13, 6'h2A);
    prog[13] = rt_i(7, 1, 14, 6'h2B);
    prog[14] = im_i(6'h2B, 0, 5, 16'd12);
    prog[15] = im_i(6'h23, 0, 15, 16'd12);
    prog[16] = im_i(6'h0D, 0, 17, 16'd16);
    prog[17] = im_i(6'h23, 17, 16, 16'hfffc);
    prog[18] = rt_i(3, 4, 0, 6'h20);
    prog[19] = rt_i(0, 0, 18, 6'h20);
    prog[20] = im_i(6'h04, 1, 2, 16'd5);
    prog[21] = im_i(6'h04, 15, 16, 16'd2);
    prog[22] = im_i(6'h0D, 0, 19, 16'h1111);
    prog[23] = im_i(6'h0D, 0, 19, 16'h2222);
    prog[24] = jm_i(27);
    prog[25] = im_i(6'h0D, 0, 20, 16'h3333);
    prog[26] = im_i(6'h0D, 0, 20, 16'h4444);
    prog[27] = im_i(6'h04, 0, 0, 16'd1);
    prog[28] = im_i(6'h0D, 0, 21, 16'h5555);
    prog[29] = rt_i(7, 3, 21, 6'h22);
    prog[30] = im_i(6'h23, 0, 22, 16'd20);
    prog[31] = im_i(6'h04, 0, 0, 16'hffff);
    for (int i = 0; i < 32; i++) mr[i] = 0;
    for (int i = 0; i < MW; i++) begin mi[i] = 0; md[i] = 0; end
    mpc = 0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 32; i++) load(0, i, prog[i]);
    load(1, 1, 32'h7fffffff);
    load(1, 2, 32'h00000001);
    load(1, 3, 32'h0);
    load(1, 5, 32'h00005555);
    ld_valid = 0;
    // R1 / R12 reset state
    chk(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    chk(!rf_we_o, "R1", "rf_we in reset", 32'(rf_we_o), 0);
    chk(!dm_we_o, "R1", "dm_we in reset", 32'(dm_we_o), 0);
    chk(ld_ready, "R12", "ready in reset", 32'(ld_ready), 1);
    rst = 0;
    #1;
    chk(!ld_ready, "R12", "ready after reset", 32'(ld_ready), 0);
    for (int c = 0; c < 70; c++) begin
      step();
      // R12: words offered while not ready must not land in the data store
      if (c >= 2 && c < 6) begin
        ld_valid = 1; ld_dmem = 1; ld_index = AW'(5); ld_data = 32'hdead0000;
      end else ld_valid = 0;
      @(negedge clk); #1;
    end
    chk(mr[22] == 32'h00005555, "R12", "ignored load", mr[22], 32'h00005555);
    chk(mpc == 32'd124, "R8", "backward self loop", mpc, 32'd124);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule